// File: doc/BRIEF.md
# Overcharge Protection Latch Controller

This block is the digital control core of a multi-cell overcharge protector. It runs on a slow internal tick, which is the clock input here, so every delay is a count of ticks. Two comparator flags come in. One reports that some cell is above the overcharge threshold. The other reports that every cell is below the release level, which is the threshold minus the hysteresis. The block drives one active-high output that cuts the charge path.

Detection uses a delay timer with a noise filter. A short dip below the threshold lets the count keep running. Only a dip that lasts the timer-reset delay clears the count. Once the output is set, it stays latched. Two things are needed to clear it. First, the release delay must have completed with all cells low. Second, a fresh low-to-high edge must then arrive on a control pin. An undervoltage-lockout input clears everything.

A test-entry condition held long enough latches a test mode. In test mode the detection delay is cut to one sixty-fourth of its normal length. The other delays keep their normal length. The test latch clears when the output fires.

Top module: `ovc_guard`

## Requirements
- R1: While `rst` is high, and on the edge after it is sampled high, `charge_cut` is low, all timers are cleared and test mode is off.
- R2: In normal mode, `charge_cut` rises exactly DET_TICKS ticks after the synchronized `over_any` is first seen high. The synchronizer adds two ticks of latency, so the output is high DET_TICKS+2 edges after the input rises.
- R3: While detection is counting, a low period of `over_any` shorter than TR_TICKS ticks does not stop or clear the count. The count keeps advancing through the dip.
- R4: A low period of `over_any` lasting TR_TICKS ticks clears the detection count. Counting restarts from zero only when `over_any` is high again.
- R5: After firing, the overcharge status releases only after `all_below` has been high for REL_TICKS consecutive ticks. Release alone leaves `charge_cut` high.
- R6: After release, a rising edge on `clr_pin` clears `charge_cut` three edges after the pin rises: two synchronizer stages plus one edge-detect tick.
- R7: A `clr_pin` rising edge that arrives before release completes is discarded and not remembered. A pin held high or held low never clears the output.
- R8: A pulse on `uvlo` clears `charge_cut`, the overcharge status and the test-mode latch two edges after it is sampled.
- R9: When `test_req` has been high for TST_TICKS consecutive synchronized ticks, test mode is entered. It stays set after `test_req` goes low.
- R10: In test mode the detection delay is DET_TICKS>>TEST_SHIFT ticks. The dip filter (TR_TICKS) and the release delay (REL_TICKS) are unchanged.
- R11: Firing the output clears test mode, so the next detection takes the full DET_TICKS.
- R12: A `test_req` high period shorter than TST_TICKS does not enter test mode. Each low tick restarts the entry count.
- R13: Any tick with `all_below` low during the release delay restarts the release count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst | input | 1 | Synchronous active-high reset |
| over_any | input | 1 | Asynchronous: some cell is above the overcharge threshold |
| all_below | input | 1 | Asynchronous: every cell is below threshold minus hysteresis |
| clr_pin | input | 1 | Asynchronous latch-clear control; acts on its rising edge |
| test_req | input | 1 | Asynchronous test-mode entry condition |
| uvlo | input | 1 | Asynchronous undervoltage-lockout reset |
| charge_cut | output | 1 | Active-high charge-cut output |

## Verification
`charge_cut` is the only output, so every internal error has to show up as a wrong time for the output to rise or fall. The rise is checked on exact tick boundaries: low at DET_TICKS+1 edges and high at DET_TICKS+2.

- A detection counter that a short dip wrongly cleared makes the rise late.
- A missed long-dip clear makes the rise early.
- A stale test-mode latch makes the rise DET_TICKS minus the fast delay too early.

A remembered early clear edge, or a release counter that fails to restart, shows up as a `charge_cut` that drops after the next edge on `clr_pin`, when it should have stayed high.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic [1:0] {
        DT_IDLE = 2'd0,
        DT_RUN  = 2'd1,
        DT_DIP  = 2'd2
    } det_st_e;

    typedef struct packed {
        logic over;
        logic below;
        logic clr;
        logic test;
        logic uvlo;
    } ovc_in_t;

    localparam int unsigned IN_W = 5;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int unsigned fast_limit(input int unsigned det, input int unsigned shift);
        return ((det >> shift) == 0) ? 1 : (det >> shift);
    endfunction

endpackage

// File: rtl/ovc_sync.sv
module ovc_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                q_sync[i] <= 1'b0;
            end else begin
                stage1[i] <= d_async[i];
                q_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/ovc_det_timer.sv
module ovc_det_timer
    import ovc_pkg::*;
#(
    parameter int unsigned DET_TICKS  = 4000,
    parameter int unsigned TR_TICKS   = 15,
    parameter int unsigned TEST_SHIFT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic over,
    input  logic tmode,
    output logic fire
);
    localparam int unsigned CW   = cnt_width(DET_TICKS);
    localparam int unsigned TW   = cnt_width(TR_TICKS);
    localparam int unsigned FAST = fast_limit(DET_TICKS, TEST_SHIFT);
    localparam logic [CW:0] LIM_NORM = (CW+1)'(DET_TICKS);
    localparam logic [CW:0] LIM_FAST = (CW+1)'(FAST);
    localparam logic [TW:0] LIM_DIP  = (TW+1)'(TR_TICKS);

    det_st_e       st;
    logic [CW-1:0] cnt;
    logic [TW-1:0] dip;
    logic [CW:0]   cnt_nx;
    logic [TW:0]   dip_nx;
    logic [CW:0]   limit;

    assign limit  = tmode ? LIM_FAST : LIM_NORM;
    assign cnt_nx = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign dip_nx = {1'b0, dip} + {{TW{1'b0}}, 1'b1};

    always_comb begin
        fire = 1'b0;
        if (en) begin
            if (st == DT_IDLE) begin
                fire = over && (limit <= {{CW{1'b0}}, 1'b1});
            end else begin
                fire = (cnt_nx >= limit);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !en || fire) begin
            st  <= DT_IDLE;
            cnt <= '0;
            dip <= '0;
        end else begin
            case (st)
                DT_IDLE: begin
                    if (over) begin
                        st  <= DT_RUN;
                        cnt <= {{(CW-1){1'b0}}, 1'b1};
                        dip <= '0;
                    end
                end
                DT_RUN, DT_DIP: begin
                    cnt <= cnt_nx[CW-1:0];
                    if (over) begin
                        st  <= DT_RUN;
                        dip <= '0;
                    end else if (dip_nx >= LIM_DIP) begin
                        st  <= DT_IDLE;
                        cnt <= '0;
                        dip <= '0;
                    end else begin
                        st  <= DT_DIP;
                        dip <= dip_nx[TW-1:0];
                    end
                end
                default: begin
                    st  <= DT_IDLE;
                    cnt <= '0;
                    dip <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ovc_rel_timer.sv
module ovc_rel_timer
    import ovc_pkg::*;
#(
    parameter int unsigned REL_TICKS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic active,
    input  logic below,
    output logic done
);
    localparam int unsigned RW = cnt_width(REL_TICKS);
    localparam logic [RW:0] LIM_REL = (RW+1)'(REL_TICKS);

    logic [RW-1:0] cnt;
    logic [RW:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt} + {{RW{1'b0}}, 1'b1};
    assign done   = active && below && (cnt_nx >= LIM_REL);

    always_ff @(posedge clk) begin
        if (rst || clr || !active || !below || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nx[RW-1:0];
        end
    end
endmodule

// File: rtl/ovc_test_latch.sv
module ovc_test_latch
    import ovc_pkg::*;
#(
    parameter int unsigned TST_TICKS = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic entry,
    input  logic leave,
    output logic tmode
);
    localparam int unsigned EW = cnt_width(TST_TICKS);
    localparam logic [EW:0] LIM_TST = (EW+1)'(TST_TICKS);

    logic [EW-1:0] cnt;
    logic [EW:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt} + {{EW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tmode <= 1'b0;
            cnt   <= '0;
        end else if (leave) begin
            tmode <= 1'b0;
            cnt   <= '0;
        end else if (!entry) begin
            cnt <= '0;
        end else if (!tmode) begin
            if (cnt_nx >= LIM_TST) begin
                tmode <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt_nx[EW-1:0];
            end
        end
    end
endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
    import ovc_pkg::*;
#(
    parameter int unsigned DET_TICKS  = 4000,
    parameter int unsigned TR_TICKS   = 15,
    parameter int unsigned REL_TICKS  = 60,
    parameter int unsigned TST_TICKS  = 80,
    parameter int unsigned TEST_SHIFT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic over_any,
    input  logic all_below,
    input  logic clr_pin,
    input  logic test_req,
    input  logic uvlo,
    output logic charge_cut
);
    ovc_in_t raw_in;
    ovc_in_t syn_in;
    logic    s_uvlo;
    logic    clr_d;
    logic    ctl_edge;
    logic    ovc_stat;
    logic    tmode;
    logic    det_fire;
    logic    rel_done;

    assign raw_in = '{over: over_any, below: all_below, clr: clr_pin,
                      test: test_req, uvlo: uvlo};

    ovc_sync #(.W(IN_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    assign s_uvlo   = syn_in.uvlo;
    assign ctl_edge = syn_in.clr && !clr_d;

    ovc_det_timer #(
        .DET_TICKS  (DET_TICKS),
        .TR_TICKS   (TR_TICKS),
        .TEST_SHIFT (TEST_SHIFT)
    ) u_det (
        .clk   (clk),
        .rst   (rst),
        .clr   (s_uvlo),
        .en    (!ovc_stat),
        .over  (syn_in.over),
        .tmode (tmode),
        .fire  (det_fire)
    );

    ovc_rel_timer #(.REL_TICKS(REL_TICKS)) u_rel (
        .clk    (clk),
        .rst    (rst),
        .clr    (s_uvlo),
        .active (ovc_stat),
        .below  (syn_in.below),
        .done   (rel_done)
    );

    ovc_test_latch #(.TST_TICKS(TST_TICKS)) u_tst (
        .clk   (clk),
        .rst   (rst),
        .clr   (s_uvlo),
        .entry (syn_in.test),
        .leave (det_fire),
        .tmode (tmode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_d <= 1'b0;
        end else begin
            clr_d <= syn_in.clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || s_uvlo) begin
            ovc_stat <= 1'b0;
        end else if (det_fire) begin
            ovc_stat <= 1'b1;
        end else if (rel_done) begin
            ovc_stat <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || s_uvlo) begin
            charge_cut <= 1'b0;
        end else if (det_fire) begin
            charge_cut <= 1'b1;
        end else if (ctl_edge && !ovc_stat) begin
            charge_cut <= 1'b0;
        end
    end
endmodule

// File: rtl/ovc_guard_chk.sv
module ovc_guard_chk (
    input logic clk,
    input logic rst,
    input logic s_uvlo,
    input logic fire,
    input logic ovc_stat,
    input logic tmode,
    input logic charge_cut,
    input logic ctl_edge
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !charge_cut);

    a_r8_uvlo_clears: assert property (@(posedge clk) disable iff (rst)
        s_uvlo |=> (!charge_cut && !tmode && !ovc_stat));

    a_r6_fall_needs_edge: assert property (@(posedge clk) disable iff (rst)
        ($fell(charge_cut) && !$past(s_uvlo) && !$past(rst)) |-> $past(ctl_edge));

    a_r7_hold_until_release: assert property (@(posedge clk) disable iff (rst)
        (ovc_stat && !s_uvlo) |=> charge_cut);

    a_r2_rise_sets_status: assert property (@(posedge clk) disable iff (rst)
        $rose(charge_cut) |-> ovc_stat);

    a_r11_fire_leaves_test: assert property (@(posedge clk) disable iff (rst)
        fire |=> !tmode);
endmodule

bind ovc_guard ovc_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_uvlo     (s_uvlo),
    .fire       (det_fire),
    .ovc_stat   (ovc_stat),
    .tmode      (tmode),
    .charge_cut (charge_cut),
    .ctl_edge   (ctl_edge)
);

// File: tb/sim_ovc_guard.sv
`timescale 1ns/1ps
module sim_ovc_guard;
    localparam int DET  = 512;
    localparam int TR   = 4;
    localparam int REL  = 6;
    localparam int TST  = 8;
    localparam int SH   = 6;
    localparam int FAST = DET >> SH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic over_any = 1'b0, all_below = 1'b0, clr_pin = 1'b0;
    logic test_req = 1'b0, uvlo = 1'b0;
    logic charge_cut;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    ovc_guard #(
        .DET_TICKS(DET), .TR_TICKS(TR), .REL_TICKS(REL),
        .TST_TICKS(TST), .TEST_SHIFT(SH)
    ) u0 (
        .clk(clk), .rst(rst), .over_any(over_any), .all_below(all_below),
        .clr_pin(clr_pin), .test_req(test_req), .uvlo(uvlo),
        .charge_cut(charge_cut)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: charge_cut=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fire_normal(input string req);
        over_any = 1'b1;
        step(DET + 1);
        chk(charge_cut, 1'b0, req);
        step(1);
        chk(charge_cut, 1'b1, req);
        over_any = 1'b0;
    endtask

    task automatic clear_all();
        over_any  = 1'b0;
        all_below = 1'b1;
        step(REL + 4);
        clr_pin = 1'b1;
        step(4);
        chk(charge_cut, 1'b0, "R6");
        clr_pin   = 1'b0;
        all_below = 1'b0;
        step(3);
    endtask

    task automatic enter_test();
        test_req = 1'b1;
        step(TST + 3);
        test_req = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        chk(charge_cut, 1'b0, "R1");
        rst = 1'b0;
        step(2);

        // R2: basic detection delay
        fire_normal("R2");
        clear_all();

        // R5 and R6: release keeps output, exact clear latency
        over_any = 1'b1;
        step(DET + 2);
        chk(charge_cut, 1'b1, "R2");
        over_any  = 1'b0;
        all_below = 1'b1;
        step(REL + 4);
        chk(charge_cut, 1'b1, "R5");
        clr_pin = 1'b1;
        step(2);
        chk(charge_cut, 1'b1, "R6");
        step(1);
        chk(charge_cut, 1'b0, "R6");
        clr_pin   = 1'b0;
        all_below = 1'b0;
        step(3);

        // R3: short dip keeps counting
        over_any = 1'b1;
        step(5);
        over_any = 1'b0;
        step(TR - 1);
        over_any = 1'b1;
        step(DET + 1 - 5 - (TR - 1));
        chk(charge_cut, 1'b0, "R3");
        step(1);
        chk(charge_cut, 1'b1, "R3");
        clear_all();

        // R4: long dip clears the count
        over_any = 1'b1;
        step(5);
        over_any = 1'b0;
        step(TR);
        fire_normal("R4");
        clear_all();

        // R7: early edge discarded, held-high pin does not clear
        over_any = 1'b1;
        step(DET + 2);
        over_any  = 1'b0;
        clr_pin   = 1'b1;
        all_below = 1'b1;
        step(REL + 5);
        chk(charge_cut, 1'b1, "R7");
        clr_pin = 1'b0;
        step(3);
        chk(charge_cut, 1'b1, "R7");
        clr_pin = 1'b1;
        step(3);
        chk(charge_cut, 1'b0, "R6");
        clr_pin   = 1'b0;
        all_below = 1'b0;
        step(3);

        // R13: interrupted release restarts
        over_any = 1'b1;
        step(DET + 2);
        over_any  = 1'b0;
        all_below = 1'b1;
        step(3);
        all_below = 1'b0;
        step(1);
        all_below = 1'b1;
        step(4);
        all_below = 1'b0;
        step(4);
        clr_pin = 1'b1;
        step(4);
        chk(charge_cut, 1'b1, "R13");
        clr_pin = 1'b0;
        step(1);
        clear_all();

        // R9 and R10: test mode shortens detection
        enter_test();
        over_any = 1'b1;
        step(FAST + 1);
        chk(charge_cut, 1'b0, "R10");
        step(1);
        chk(charge_cut, 1'b1, "R9");
        over_any = 1'b0;
        clear_all();

        // R11: firing left test mode
        over_any = 1'b1;
        step(FAST + 2);
        chk(charge_cut, 1'b0, "R11");
        step(DET - FAST - 1);
        chk(charge_cut, 1'b0, "R11");
        step(1);
        chk(charge_cut, 1'b1, "R11");
        clear_all();

        // R12: short entry periods do not enter test mode
        test_req = 1'b1;
        step(TST - 1);
        test_req = 1'b0;
        step(1);
        test_req = 1'b1;
        step(TST - 1);
        test_req = 1'b0;
        step(2);
        over_any = 1'b1;
        step(FAST + 2);
        chk(charge_cut, 1'b0, "R12");
        step(DET - FAST);
        chk(charge_cut, 1'b1, "R12");
        clear_all();

        // R10: dip filter length unchanged in test mode
        enter_test();
        over_any = 1'b1;
        step(2);
        over_any = 1'b0;
        step(TR - 1);
        over_any = 1'b1;
        step(FAST + 1 - 2 - (TR - 1));
        chk(charge_cut, 1'b0, "R10");
        step(1);
        chk(charge_cut, 1'b1, "R10");
        clear_all();

        // R8: undervoltage clears output and test mode
        over_any = 1'b1;
        step(DET + 2);
        over_any = 1'b0;
        enter_test();
        uvlo = 1'b1;
        step(1);
        uvlo = 1'b0;
        step(2);
        chk(charge_cut, 1'b0, "R8");
        over_any = 1'b1;
        step(FAST + 2);
        chk(charge_cut, 1'b0, "R8");
        step(DET - FAST);
        chk(charge_cut, 1'b1, "R8");

        // R1: reset while latched
        rst = 1'b1;
        over_any = 1'b0;
        step(2);
        chk(charge_cut, 1'b0, "R1");
        rst = 1'b0;
        step(2);
        chk(charge_cut, 1'b0, "R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R0: watchdog expired, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule